// File: doc/BRIEF.md
# Frequency Sweep and Modulation Unit

This block owns the 11-bit pitch word of a single wave channel and rewrites it on a programmable schedule. It has two modes. In sweep mode, each update adds or subtracts a right-shifted copy of the present frequency. In table mode, each update adds an entry of a 32-entry offset table to the frequency that the host last loaded, and the table index steps forward once per update.

The block works one update ahead. The value that the next timer expiry will load is held in a staging register. It is rebuilt at once whenever the host writes a field that affects it, when the channel is started, and when an update consumes it. A sweep result that does not fit in 11 bits raises a one-cycle request to silence the channel. The waveform generator that consumes the frequency is outside this block.

Top module: `fmod_unit`

## Requirements
- R1: After a synchronous reset, `freq_out` is 0 and `off_req` is 0.
- R2: A frequency write (`freq_we`) drives `freq_out` to `freq_wdata` on the next clock edge. It also becomes the base value for table mode.
- R3: Sweep mode with `swp_dir`=0 loads `f - (f >> swp_shift)` on each update, where `f` is the present frequency.
- R4: Sweep mode with `swp_dir`=1 loads `f + (f >> swp_shift)` on each update.
- R5: If a staged sweep sum exceeds 2047 while the enable bit is set, `off_req` is 1 for exactly the cycle after the event that computed that sum.
- R6: Table mode (`cfg_mode`=1) loads `(base + table[idx]) mod 2048` on each update, and `idx` then steps forward by one.
- R7: At index 31, the next update wraps `idx` to 0 when `cfg_repeat` is 1, and holds it at 31 when `cfg_repeat` is 0.
- R8: Updates occur every `swp_interval` × FAST_TICKS cycles when `swp_clk_sel`=0, and every `swp_interval` × SLOW_TICKS cycles when `swp_clk_sel`=1. The count is taken from the start strobe or from the previous update. `freq_out` does not change earlier.
- R9: When `cfg_enable` is 0 or `swp_interval` is 0, no update occurs and `freq_out` holds.
- R10: A sweep-register write replaces the remaining time only when its new period is shorter than that remaining time. Otherwise the running count continues.
- R11: `start` reloads the timer with a full period and returns the table index to 0.
- R12: Table writes are ignored while `ch_active` is 1.
- R13: A write to the sweep, mode or frequency fields between updates recomputes the staged value, and the next update uses the new fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_enable | input | 1 | Unit enable |
| cfg_mode | input | 1 | 0 selects sweep, 1 selects table |
| cfg_repeat | input | 1 | Table index wraps after entry 31 |
| swp_we | input | 1 | Sweep register write strobe |
| swp_clk_sel | input | 1 | 0 selects the fast tick base, 1 the slow one |
| swp_interval | input | 3 | Update interval in tick units |
| swp_dir | input | 1 | 0 subtracts the step, 1 adds it |
| swp_shift | input | 3 | Right shift applied to form the sweep step |
| freq_we | input | 1 | Frequency write strobe |
| freq_wdata | input | 11 | Frequency written by the host |
| tab_we | input | 1 | Offset table write strobe |
| tab_addr | input | 5 | Offset table write address |
| tab_wdata | input | 8 | Offset table write data (unsigned) |
| ch_active | input | 1 | Channel is playing; the timer runs only while high |
| start | input | 1 | Channel start strobe |
| freq_out | output | 11 | Current channel frequency |
| off_req | output | 1 | One-cycle request to disable the channel |

## Verification
The checker assumes that every host access arrives as a single-cycle strobe. It also assumes that `start` and `freq_we` do not fall on the same cycle as an expiry, because those cycles follow an override order rather than the plain update rule. The directed bench issues one strobe per task and keeps the table writes with `ch_active` low, except in the case that checks the write lock. It counts each wait in clock edges from the start strobe or from a write, so every sample lands inside one known timer window.

// File: rtl/fmod_pkg.sv
package fmod_pkg;
  localparam int IVL_W   = 3;
  localparam int SHIFT_W = 3;

  typedef enum logic {
    MODE_SWEEP = 1'b0,
    MODE_TABLE = 1'b1
  } fmod_mode_e;

  typedef struct packed {
    logic               clk_sel;
    logic [IVL_W-1:0]   interval;
    logic               dir;
    logic [SHIFT_W-1:0] shift;
  } sweep_cfg_t;
endpackage

// File: rtl/fmod_table.sv
module fmod_table #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fmod_calc.sv
module fmod_calc
  import fmod_pkg::*;
#(
  parameter int FREQ_W = 11,
  parameter int TAB_W  = 8
) (
  input  fmod_mode_e          mode,
  input  logic                dir,
  input  logic [SHIFT_W-1:0]  shift,
  input  logic [FREQ_W-1:0]   cur,
  input  logic [FREQ_W-1:0]   base,
  input  logic [TAB_W-1:0]    offset,
  output logic [FREQ_W-1:0]   nxt,
  output logic                ovf
);
  logic [FREQ_W-1:0] step;
  logic [FREQ_W:0]   up_sum;
  logic [FREQ_W-1:0] down_val;
  logic [FREQ_W-1:0] tab_sum;

  always_comb begin
    step     = cur >> shift;
    up_sum   = {1'b0, cur} + {1'b0, step};
    down_val = cur - step;
    tab_sum  = base + FREQ_W'(offset);
    if (mode == MODE_SWEEP) begin
      nxt = dir ? up_sum[FREQ_W-1:0] : down_val;
      ovf = dir & up_sum[FREQ_W];
    end else begin
      nxt = tab_sum;
      ovf = 1'b0;
    end
  end
endmodule

// File: rtl/fmod_timer.sv
module fmod_timer
  import fmod_pkg::*;
#(
  parameter int FAST_TICKS = 19200,
  parameter int SLOW_TICKS = 153600,
  localparam int CNT_W = $clog2(SLOW_TICKS * ((1 << IVL_W) - 1) + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             start,
  input  logic             shrink_req,
  input  logic [IVL_W-1:0] ivl_cur,
  input  logic             sel_cur,
  input  logic [IVL_W-1:0] ivl_new,
  input  logic             sel_new,
  output logic             expire,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_cur;
  logic [CNT_W-1:0] load_new;

  function automatic logic [CNT_W-1:0] period(input logic [IVL_W-1:0] ivl,
                                              input logic sel);
    logic [CNT_W-1:0] base;
    base = sel ? CNT_W'(SLOW_TICKS) : CNT_W'(FAST_TICKS);
    return CNT_W'(ivl) * base;
  endfunction

  assign load_cur = period(ivl_cur, sel_cur);
  assign load_new = period(ivl_new, sel_new);
  assign expire   = run && (cnt_q <= CNT_W'(1));
  assign cnt      = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= load_cur;
    end else if (shrink_req && (load_new < cnt_q)) begin
      cnt_q <= load_new;
    end else if (expire) begin
      cnt_q <= load_cur;
    end else if (run) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/fmod_unit.sv
module fmod_unit
  import fmod_pkg::*;
#(
  parameter int FREQ_W     = 11,
  parameter int TAB_DEPTH  = 32,
  parameter int TAB_W      = 8,
  parameter int FAST_TICKS = 19200,
  parameter int SLOW_TICKS = 153600,
  localparam int IDX_W     = $clog2(TAB_DEPTH),
  localparam int CNT_W     = $clog2(SLOW_TICKS * ((1 << IVL_W) - 1) + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic               cfg_enable,
  input  logic               cfg_mode,
  input  logic               cfg_repeat,
  input  logic               swp_we,
  input  logic               swp_clk_sel,
  input  logic [IVL_W-1:0]   swp_interval,
  input  logic               swp_dir,
  input  logic [SHIFT_W-1:0] swp_shift,
  input  logic               freq_we,
  input  logic [FREQ_W-1:0]  freq_wdata,
  input  logic               tab_we,
  input  logic [IDX_W-1:0]   tab_addr,
  input  logic [TAB_W-1:0]   tab_wdata,
  input  logic               ch_active,
  input  logic               start,
  output logic [FREQ_W-1:0]  freq_out,
  output logic               off_req
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TAB_DEPTH - 1);

  // registered configuration and datapath state
  logic              en_q, rep_q;
  fmod_mode_e        mode_q;
  sweep_cfg_t        swp_q;
  logic [FREQ_W-1:0] cur_q, base_q, next_q;
  logic [IDX_W-1:0]  idx_q;
  logic              off_q;

  // post-write views used for staging
  logic              en_d, rep_d;
  fmod_mode_e        mode_d;
  sweep_cfg_t        swp_d;
  logic [FREQ_W-1:0] cur_d, base_d, next_d;
  logic [IDX_W-1:0]  idx_d, idx_adv;
  logic              off_d;

  logic              act, run, expire, upd, restage;
  logic [CNT_W-1:0]  timer_q;
  logic [TAB_W-1:0]  tab_val;
  logic [FREQ_W-1:0] calc_nxt;
  logic              calc_ovf;

  assign act = en_q && (swp_q.interval != '0);
  assign run = act && ch_active && !start;
  assign upd = expire && !freq_we;

  fmod_timer #(
    .FAST_TICKS (FAST_TICKS),
    .SLOW_TICKS (SLOW_TICKS)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .start      (start),
    .shrink_req (swp_we),
    .ivl_cur    (swp_q.interval),
    .sel_cur    (swp_q.clk_sel),
    .ivl_new    (swp_interval),
    .sel_new    (swp_clk_sel),
    .expire     (expire),
    .cnt        (timer_q)
  );

  fmod_table #(
    .DEPTH (TAB_DEPTH),
    .W     (TAB_W)
  ) u_table (
    .clk   (clk),
    .we    (tab_we && !ch_active),
    .waddr (tab_addr),
    .wdata (tab_wdata),
    .raddr (idx_d),
    .rdata (tab_val)
  );

  always_comb begin
    en_d   = cfg_we ? cfg_enable : en_q;
    rep_d  = cfg_we ? cfg_repeat : rep_q;
    mode_d = cfg_we ? fmod_mode_e'(cfg_mode) : mode_q;
    swp_d  = swp_q;
    if (swp_we) begin
      swp_d.clk_sel  = swp_clk_sel;
      swp_d.interval = swp_interval;
      swp_d.dir      = swp_dir;
      swp_d.shift    = swp_shift;
    end

    base_d = freq_we ? freq_wdata : base_q;
    if (freq_we)  cur_d = freq_wdata;
    else if (upd) cur_d = next_q;
    else          cur_d = cur_q;

    if (idx_q == LAST_IDX) idx_adv = rep_q ? '0 : idx_q;
    else                   idx_adv = idx_q + IDX_W'(1);

    if (start)                           idx_d = '0;
    else if (upd && mode_q == MODE_TABLE) idx_d = idx_adv;
    else                                  idx_d = idx_q;
  end

  fmod_calc #(
    .FREQ_W (FREQ_W),
    .TAB_W  (TAB_W)
  ) u_calc (
    .mode   (mode_d),
    .dir    (swp_d.dir),
    .shift  (swp_d.shift),
    .cur    (cur_d),
    .base   (base_d),
    .offset (tab_val),
    .nxt    (calc_nxt),
    .ovf    (calc_ovf)
  );

  assign restage = start | freq_we | cfg_we | swp_we | upd;
  assign next_d  = restage ? calc_nxt : next_q;
  assign off_d   = restage && calc_ovf && en_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      rep_q  <= 1'b0;
      mode_q <= MODE_SWEEP;
      swp_q  <= '0;
      cur_q  <= '0;
      base_q <= '0;
      next_q <= '0;
      idx_q  <= '0;
      off_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      rep_q  <= rep_d;
      mode_q <= mode_d;
      swp_q  <= swp_d;
      cur_q  <= cur_d;
      base_q <= base_d;
      next_q <= next_d;
      idx_q  <= idx_d;
      off_q  <= off_d;
    end
  end

  assign freq_out = cur_q;
  assign off_req  = off_q;
endmodule

// File: rtl/fmod_unit_chk.sv
module fmod_unit_chk
  import fmod_pkg::*;
#(
  parameter int FREQ_W = 11,
  parameter int IDX_W  = 5,
  parameter int CNT_W  = 21
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              freq_we,
  input logic              swp_we,
  input logic [FREQ_W-1:0] freq_out,
  input logic              off_req,
  input logic              act,
  input logic              rep_q,
  input fmod_mode_e        mode_q,
  input logic [IDX_W-1:0]  idx_q,
  input logic [CNT_W-1:0]  timer_q
);
  localparam logic [IDX_W-1:0] LAST = '1;

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (freq_out == '0 && !off_req));

  // R5
  a_r5_off_only_sweep: assert property (@(posedge clk) disable iff (rst)
    off_req |-> mode_q == MODE_SWEEP);

  // R7
  a_r7_idx_holds_last: assert property (@(posedge clk) disable iff (rst)
    (idx_q == LAST && !rep_q && !start) |=> idx_q == LAST);

  // R8
  a_r8_no_early_update: assert property (@(posedge clk) disable iff (rst)
    (timer_q > CNT_W'(1) && !freq_we) |=> $stable(freq_out));

  // R9
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!act && !freq_we) |=> $stable(freq_out));

  // R10
  a_r10_never_lengthens: assert property (@(posedge clk) disable iff (rst)
    (swp_we && !start && timer_q > CNT_W'(1)) |=> timer_q <= $past(timer_q));

  // R11
  a_r11_start_rewinds: assert property (@(posedge clk) disable iff (rst)
    start |=> idx_q == '0);
endmodule

bind fmod_unit fmod_unit_chk #(
  .FREQ_W (FREQ_W),
  .IDX_W  (IDX_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .freq_we  (freq_we),
  .swp_we   (swp_we),
  .freq_out (freq_out),
  .off_req  (off_req),
  .act      (act),
  .rep_q    (rep_q),
  .mode_q   (mode_q),
  .idx_q    (idx_q),
  .timer_q  (timer_q)
);

// File: tb/fmod_unit_test.sv
module fmod_unit_test;
  localparam int FAST = 4;
  localparam int SLOW = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 0, cfg_enable = 0, cfg_mode = 0, cfg_repeat = 0;
  logic        swp_we = 0, swp_clk_sel = 0, swp_dir = 0;
  logic [2:0]  swp_interval = 0, swp_shift = 0;
  logic        freq_we = 0;
  logic [10:0] freq_wdata = 0;
  logic        tab_we = 0;
  logic [4:0]  tab_addr = 0;
  logic [7:0]  tab_wdata = 0;
  logic        ch_active = 0, start = 0;
  logic [10:0] freq_out;
  logic        off_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  fmod_unit #(.FAST_TICKS(FAST), .SLOW_TICKS(SLOW)) uut (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode), .cfg_repeat(cfg_repeat),
    .swp_we(swp_we), .swp_clk_sel(swp_clk_sel), .swp_interval(swp_interval),
    .swp_dir(swp_dir), .swp_shift(swp_shift),
    .freq_we(freq_we), .freq_wdata(freq_wdata),
    .tab_we(tab_we), .tab_addr(tab_addr), .tab_wdata(tab_wdata),
    .ch_active(ch_active), .start(start),
    .freq_out(freq_out), .off_req(off_req)
  );

  always #5 clk = ~clk;

  function automatic int tval(input int i);
    return (i * 7 + 3) & 255;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; ch_active = 1'b0;
    edges(2);
    rst = 1'b0;
  endtask

  task automatic wr_cfg(input logic en, input logic md, input logic rp);
    cfg_we = 1; cfg_enable = en; cfg_mode = md; cfg_repeat = rp;
    edges(1);
    cfg_we = 0;
  endtask

  task automatic wr_swp(input logic sel, input int ivl, input logic dir, input int sh);
    swp_we = 1; swp_clk_sel = sel; swp_interval = 3'(ivl); swp_dir = dir; swp_shift = 3'(sh);
    edges(1);
    swp_we = 0;
  endtask

  task automatic wr_freq(input int f);
    freq_we = 1; freq_wdata = 11'(f);
    edges(1);
    freq_we = 0;
  endtask

  task automatic wr_tab(input int a, input int d);
    tab_we = 1; tab_addr = 5'(a); tab_wdata = 8'(d);
    edges(1);
    tab_we = 0;
  endtask

  task automatic go();
    ch_active = 1; start = 1;
    edges(1);
    start = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 freq after reset", int'(freq_out), 0);
    chk("R1 off after reset", int'(off_req), 0);
    for (int i = 0; i < 32; i++) wr_tab(i, tval(i));
  endtask

  task automatic t_sweep_down();
    do_reset();
    wr_freq(1024);
    chk("R2 freq write", int'(freq_out), 1024);
    wr_swp(0, 1, 0, 2);
    wr_cfg(1, 0, 0);
    go();
    edges(3);
    chk("R8 fast period not early", int'(freq_out), 1024);
    edges(1);
    chk("R3 first down step", int'(freq_out), 768);
    edges(4);
    chk("R3 second down step", int'(freq_out), 576);
  endtask

  task automatic t_sweep_up();
    do_reset();
    wr_freq(1024);
    wr_swp(1, 1, 1, 3);
    wr_cfg(1, 0, 0);
    go();
    edges(SLOW - 1);
    chk("R8 slow period not early", int'(freq_out), 1024);
    edges(1);
    chk("R4 up step", int'(freq_out), 1152);
  endtask

  task automatic t_overflow();
    do_reset();
    wr_freq(1000);
    wr_swp(0, 1, 1, 0);
    wr_cfg(1, 0, 0);
    go();
    edges(3);
    chk("R5 no request before", int'(off_req), 0);
    edges(1);
    chk("R4 doubled", int'(freq_out), 2000);
    chk("R5 request raised", int'(off_req), 1);
    edges(1);
    chk("R5 request one cycle", int'(off_req), 0);
  endtask

  task automatic t_table(input logic rp);
    do_reset();
    wr_freq(2040);
    wr_swp(0, 1, 0, 0);
    wr_cfg(1, 1, rp);
    go();
    for (int k = 1; k <= 34; k++) begin
      int ix;
      edges(FAST);
      if (k <= 32) ix = k - 1;
      else ix = rp ? k - 33 : 31;
      if (k <= 31) chk("R6 table step", int'(freq_out), (2040 + tval(ix)) % 2048);
      else chk(rp ? "R7 index wraps" : "R7 index holds", int'(freq_out),
               (2040 + tval(ix)) % 2048);
    end
  endtask

  task automatic t_restart();
    do_reset();
    wr_freq(100);
    wr_swp(0, 1, 0, 0);
    wr_cfg(1, 1, 0);
    go();
    edges(3 * FAST);
    chk("R6 third entry", int'(freq_out), 100 + tval(2));
    edges(2);
    go();
    edges(3);
    chk("R11 timer reloaded", int'(freq_out), 100 + tval(2));
    edges(1);
    chk("R11 index rewound", int'(freq_out), 100 + tval(0));
  endtask

  task automatic t_inactive();
    do_reset();
    wr_freq(500);
    wr_swp(0, 1, 0, 1);
    wr_cfg(0, 0, 0);
    go();
    edges(12);
    chk("R9 disabled holds", int'(freq_out), 500);
    wr_swp(0, 0, 0, 1);
    wr_cfg(1, 0, 0);
    edges(12);
    chk("R9 zero interval holds", int'(freq_out), 500);
  endtask

  task automatic t_shrink();
    do_reset();
    wr_freq(1000);
    wr_swp(0, 7, 0, 1);
    wr_cfg(1, 0, 0);
    go();
    edges(5);
    wr_swp(0, 2, 0, 1);
    edges(7);
    chk("R10 shortened not early", int'(freq_out), 1000);
    edges(1);
    chk("R10 shortened fires", int'(freq_out), 500);
    do_reset();
    wr_freq(1000);
    wr_swp(0, 2, 0, 1);
    wr_cfg(1, 0, 0);
    go();
    edges(2);
    wr_swp(0, 7, 0, 1);
    edges(4);
    chk("R10 longer kept not early", int'(freq_out), 1000);
    edges(1);
    chk("R10 longer kept fires", int'(freq_out), 500);
  endtask

  task automatic t_lock();
    do_reset();
    ch_active = 1;
    wr_tab(0, 200);
    ch_active = 0;
    wr_freq(50);
    wr_swp(0, 1, 0, 0);
    wr_cfg(1, 1, 0);
    go();
    edges(FAST);
    chk("R12 locked table kept", int'(freq_out), 50 + tval(0));
  endtask

  task automatic t_restage();
    do_reset();
    wr_freq(1024);
    wr_swp(0, 2, 0, 1);
    wr_cfg(1, 0, 0);
    go();
    edges(3);
    wr_swp(0, 2, 0, 3);
    edges(3);
    chk("R13 waits for timer", int'(freq_out), 1024);
    edges(1);
    chk("R13 new shift used", int'(freq_out), 896);
    wr_freq(800);
    chk("R2 mid-period write", int'(freq_out), 800);
    edges(6);
    chk("R13 hold after write", int'(freq_out), 800);
    edges(1);
    chk("R13 staged from written", int'(freq_out), 700);
  endtask

  initial begin
    edges(1);
    t_reset();
    t_sweep_down();
    t_sweep_up();
    t_overflow();
    t_table(1'b0);
    t_table(1'b1);
    t_restart();
    t_inactive();
    t_shrink();
    t_lock();
    t_restage();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule